// File: doc/BRIEF.md
# Processor Standby Sleep Controller

This block holds the processor core in a low-power standby state on request from software. Software sets the sleep flag by writing an auxiliary control word with the sleep bit at one. While the flag is set, the core is halted. Only interrupt detection keeps working. Any interrupt that is both requested and enabled clears the flag in hardware, and the core resumes from where it stopped. The flag never needs clearing by software.

While the core sleeps, an external stop pin can switch the processor clock off and on again. The pin first passes through a two-stage synchronizer, so the clock-gate enable follows it three clock edges later. Releasing the pin returns the core to standby rather than to execution. An interrupt can wake the core only while its clock is running. A sleep request made while the processor clock is reported as not running is discarded. The stop pin is disregarded whenever the core is awake. Oscillator power and PLL lock sequencing are handled elsewhere, and the sleep flag has no link to any power-control bits.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, `core_halt` is 0 and `clk_gate_en` is 1.
- R2: A write (`ctl_wr_en`=1) with bit 3 of `ctl_wr_data` at one, while `clk_running` is 1 and the core is awake, sets `core_halt` to 1 from the next clock edge.
- R3: A write with bit 3 at one while `clk_running` is 0 has no effect: `core_halt` stays 0.
- R4: Bits of `ctl_wr_data` other than bit 3 have no effect. A write with bit 3 at zero leaves `core_halt` at 0, whatever the other bits hold.
- R5: While `core_halt` is 1 and `clk_gate_en` is 1, a cycle in which `irq_req & irq_en` is nonzero clears `core_halt` at the next edge. The flag stays clear afterwards with no write from software.
- R6: While sleeping, a cycle in which `irq_req & irq_en` is zero leaves `core_halt` at 1. This holds for any pattern of masked requests.
- R7: While `core_halt` is 0, the stop pin `stop_req` has no effect, and `clk_gate_en` stays 1.
- R8: While sleeping, asserting `stop_req` drives `clk_gate_en` to 0 on the third clock edge after the change. Releasing it drives `clk_gate_en` back to 1 on the third edge after the release. `core_halt` stays 1 throughout.
- R9: While `clk_gate_en` is 0, enabled interrupts do not wake the core. Once the clock is re-enabled, an enabled interrupt wakes it as in R5.
- R10: Writes to the control word while `core_halt` is 1 have no effect. A write with bit 3 at zero does not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the auxiliary control word |
| ctl_wr_data | input | CTL_W (16) | Control word data; bit SLEEP_BIT (3) requests sleep |
| clk_running | input | 1 | High when the processor clock source is running |
| irq_req | input | N_IRQ (4) | Interrupt request lines |
| irq_en | input | N_IRQ (4) | Per-line interrupt enables |
| stop_req | input | 1 | Asynchronous external stop pin, active high |
| core_halt | output | 1 | Holds the core idle while sleeping |
| clk_gate_en | output | 1 | Processor clock enable, 0 stops the clock |

## Verification
The assertions assume that `irq_req`, `irq_en`, the write port and `clk_running` are synchronous to `clk`. Only `stop_req` is treated as asynchronous, and it is checked only after the synchronizer. They also assume that no write arrives while the core is halted, except where the bench issues one on purpose to test R10. The stimulus changes every input one time unit after a rising edge and samples after the next edge. This keeps each input stable across the edge that samples it. The bench holds interrupt requests at zero whenever it enters sleep or moves the stop pin, so the wake and gate timing it checks depends only on the input it is testing.

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int CTL_W     = 16,
  parameter int SLEEP_BIT = 3,
  parameter int N_IRQ     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             clk_running,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             stop_req,
  output logic             core_halt,
  output logic             clk_gate_en
);

  logic sleep_q;
  logic stop_s1, stop_s2;
  logic gated_q;
  logic irq_any;
  logic enter;
  logic wake;
  logic unused_wr_bits;

  assign unused_wr_bits = ^ctl_wr_data;
  assign irq_any = |(irq_req & irq_en);
  assign enter   = ~sleep_q & ctl_wr_en & ctl_wr_data[SLEEP_BIT] & clk_running;
  assign wake    = sleep_q & irq_any & ~gated_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else if (enter) sleep_q <= 1'b1;
    else if (wake) sleep_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_s1 <= 1'b0;
      stop_s2 <= 1'b0;
      gated_q <= 1'b0;
    end else begin
      stop_s1 <= stop_req;
      stop_s2 <= stop_s1;
      gated_q <= sleep_q & stop_s2 & ~wake;
    end
  end

  assign core_halt   = sleep_q;
  assign clk_gate_en = ~gated_q;

  assert_gate_only_in_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> core_halt);

  assert_no_entry_without_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) |-> $past(clk_running) && $past(ctl_wr_en));

  assert_wake_on_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && clk_gate_en && (|(irq_req & irq_en))) |=> !core_halt);

  assert_hold_when_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && !(|(irq_req & irq_en))) |=> core_halt);

  assert_no_wake_while_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && !clk_gate_en) |=> core_halt);

  assert_stop_ignored_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_gate_en) |-> $past(core_halt));

endmodule

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic        clk_running = 1'b1;
  logic [3:0]  irq_req = '0;
  logic [3:0]  irq_en = '0;
  logic        stop_req = 1'b0;
  logic        core_halt;
  logic        clk_gate_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  standby_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .clk_running(clk_running), .irq_req(irq_req), .irq_en(irq_en),
    .stop_req(stop_req), .core_halt(core_halt), .clk_gate_en(clk_gate_en)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter_sleep();
    ctl_wr_en = 1'b1;
    ctl_wr_data = 16'h0008;
    clk_running = 1'b1;
    step();
    ctl_wr_en = 1'b0;
    ctl_wr_data = '0;
  endtask

  initial begin
    step();
    chk("R1 halt", core_halt, 0);
    chk("R1 gate", clk_gate_en, 1);
    rst_n = 1'b1;
    step();
    chk("R1 halt after release", core_halt, 0);

    // R3: requests with clock stopped are dropped
    clk_running = 1'b0;
    ctl_wr_en = 1'b1;
    ctl_wr_data = 16'hFFFF;
    step();
    ctl_wr_en = 1'b0;
    clk_running = 1'b1;
    step();
    chk("R3 no entry without clock", core_halt, 0);

    // R4: sweep of writes with bit 3 clear
    for (int v = 0; v < 16; v++) begin
      ctl_wr_en = 1'b1;
      ctl_wr_data = 16'((v * 16'h1111) & 16'hFFF7);
      step();
      ctl_wr_en = 1'b0;
      chk("R4 other bits ignored", core_halt, 0);
    end

    // R7: stop pin while awake
    stop_req = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R7 stop ignored awake", clk_gate_en, 1);
    end
    stop_req = 1'b0;
    for (int k = 0; k < 3; k++) step();

    // R2 R5 R6: exhaustive mask x request sweep
    for (int en = 0; en < 16; en++) begin
      for (int rq = 0; rq < 16; rq++) begin
        if (!core_halt) begin
          enter_sleep();
          chk("R2 enter sleep", core_halt, 1);
        end
        irq_en = 4'(en);
        irq_req = 4'(rq);
        step();
        irq_req = '0;
        if ((en & rq) != 0) chk("R5 wake on enabled irq", core_halt, 0);
        else chk("R6 masked irq holds", core_halt, 1);
        if ((en & rq) != 0) begin
          step();
          chk("R5 flag self-cleared", core_halt, 0);
        end
      end
    end

    // R10: writes while asleep
    irq_en = 4'hF;
    if (!core_halt) enter_sleep();
    ctl_wr_en = 1'b1;
    ctl_wr_data = 16'h0000;
    step();
    ctl_wr_data = 16'hFFF7;
    step();
    ctl_wr_en = 1'b0;
    chk("R10 write ignored asleep", core_halt, 1);

    // R8 R9: stop pin during sleep
    stop_req = 1'b1;
    step();
    step();
    chk("R8 gate after two edges", clk_gate_en, 1);
    step();
    chk("R8 gate off third edge", clk_gate_en, 0);
    chk("R8 halt held", core_halt, 1);
    irq_req = 4'h1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R9 no wake while gated", core_halt, 1);
    end
    irq_req = '0;
    stop_req = 1'b0;
    step();
    step();
    chk("R8 still gated two edges", clk_gate_en, 0);
    step();
    chk("R8 gate on third edge", clk_gate_en, 1);
    chk("R8 back to standby", core_halt, 1);
    irq_req = 4'h4;
    step();
    irq_req = '0;
    chk("R9 wake after restart", core_halt, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule